// File: doc/BRIEF.md
# Coefficient Dequantizer with Half-Block AC Detection

This block sits in front of an 8x8 inverse transform. It takes in one block of 64 signed 16-bit transform coefficients together with a 64-entry multiplier table. Both arrive one row per accepted beat, row 0 first, and both are kept in internal registers. Every coefficient is multiplied by the table entry at the same position. The product keeps only its low 16 bits.

While the rows load, the block ORs the raw coefficients of rows 1 to 7 together, column by column. It then tests the left half (columns 0 to 3) and the right half (columns 4 to 7) of that map for all zeros. A half with no AC content does not pass on its products for rows 1 to 7. Instead, every row in that half's columns repeats the dequantized DC value of its own column, and the two flags tell the downstream transform which halves it may skip. The whole dequantized block and both flags are presented together on one output beat, which is held until it is accepted.

The control is a three-state machine:
- Load accepts rows. It moves to Evaluate when the beat that carries row 7 is accepted.
- Evaluate takes one cycle to register the result. It always moves to Send.
- Send holds the result. It returns to Load on the cycle that `res_ready` is seen high.

Top module: `idq_dequant`

## Requirements
- R1: A synchronous active-high reset returns the block to Load: `res_valid` is low, `row_ready` is high, and the next accepted row is row 0.
- R2: `row_ready` is high only in Load. Exactly 8 rows are accepted per block. A `row_valid` beat offered while `row_ready` is low is not stored and does not advance the row count.
- R3: Output row 0 is always the product of row 0 and table row 0, whatever the AC content.
- R4: `res_left_quiet` is high exactly when the raw coefficients of rows 1-7, columns 0-3, are all zero. `res_right_quiet` is the same test for columns 4-7. Column c of a row bus occupies bits [16c+15:16c].
- R5: The flags depend only on raw coefficients. A zero table entry does not set them, and the content of row 0 does not affect them.
- R6: When both flags are high, every output row equals dequantized row 0.
- R7: When only one flag is high, rows 1-7 of that half's columns carry that column's dequantized DC value. The other half carries its own products.
- R8: Each product is the low 16 bits of coefficient times table entry, with no saturation. Output element (r,c) sits at bits [16(8r+c)+15:16(8r+c)] of `res_data`.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and both flags stay unchanged. A beat with `res_ready` high ends Send.
- R10: `res_valid` goes high on the first rising edge after the edge that accepts row 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A coefficient row and a table row are offered |
| row_ready | output | 1 | The block accepts a row on this cycle |
| row_coef | input | 128 | Coefficient row, 8 signed 16-bit lanes |
| row_scale | input | 128 | Multiplier table row, 8 signed 16-bit lanes |
| res_valid | output | 1 | Result beat is present |
| res_ready | input | 1 | Downstream takes the result beat |
| res_data | output | 1024 | 64 dequantized 16-bit values, row-major |
| res_left_quiet | output | 1 | Columns 0-3 carry no AC energy |
| res_right_quiet | output | 1 | Columns 4-7 carry no AC energy |

## Verification
The bench sweeps a single non-zero AC coefficient through all 56 AC positions. A design that tested the wrong lane boundary, or that folded row 0 into the zero map, raises the wrong flag at a column 3/4 edge or stays quiet for an isolated DC-only block. Random blocks in all four quiet combinations, some with AC table rows set to zero, catch detection done after multiplication (a zero table entry would wrongly mark a half quiet) and filling of the wrong half or with another column's DC. Directed wrap-around products expose saturating multipliers. A reset in the middle of a load, and rows offered during backpressure, expose a row counter that is not cleared or that advances while `row_ready` is low.

// File: rtl/idq_pkg.sv
package idq_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_EVAL = 2'd1,
        ST_SEND = 2'd2
    } idq_state_e;
endpackage

// File: rtl/idq_row_store.sv
// Holds the coefficient and table rows of one block and builds the
// per-lane AC occupancy map while rows arrive.
module idq_row_store #(
    parameter  int N  = 8,
    parameter  int W  = 16,
    localparam int RW = N * W,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RW-1:0]   coef_row,
    input  logic [RW-1:0]   scale_row,
    output logic            row_last,
    output logic [N*RW-1:0] coef_flat,
    output logic [N*RW-1:0] scale_flat,
    output logic            left_quiet,
    output logic            right_quiet
);
    logic [IW-1:0] row_q;
    logic [RW-1:0] coef_q  [N];
    logic [RW-1:0] scale_q [N];
    logic [RW-1:0] ac_map_q;
    logic [N-1:0]  lane_quiet;

    assign row_last = (row_q == IW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            ac_map_q <= '0;
        end else if (wr_en) begin
            row_q <= row_last ? '0 : row_q + IW'(1);
            if (row_q == '0) begin
                ac_map_q <= '0;
            end else begin
                ac_map_q <= ac_map_q | coef_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            coef_q[row_q]  <= coef_row;
            scale_q[row_q] <= scale_row;
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_flat
        assign coef_flat[r*RW +: RW]  = coef_q[r];
        assign scale_flat[r*RW +: RW] = scale_q[r];
    end

    for (genvar c = 0; c < N; c++) begin : g_lane
        assign lane_quiet[c] = ~|ac_map_q[c*W +: W];
    end

    assign left_quiet  = &lane_quiet[N/2-1:0];
    assign right_quiet = &lane_quiet[N-1:N/2];
endmodule

// File: rtl/idq_lane_mult.sv
// One lane: wrapping W-bit product (low bits equal for signed operands).
module idq_lane_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0] coef,
    input  logic [W-1:0] scale,
    output logic [W-1:0] prod
);
    assign prod = coef * scale;
endmodule

// File: rtl/idq_fill_select.sv
// Replaces the AC rows of a quiet half with that column's DC product.
module idq_fill_select #(
    parameter  int N  = 8,
    parameter  int W  = 16,
    localparam int BW = N * N * W
) (
    input  logic [BW-1:0] prod_flat,
    input  logic          left_quiet,
    input  logic          right_quiet,
    output logic [BW-1:0] sel_flat
);
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            if (r == 0) begin : g_dc
                assign sel_flat[c*W +: W] = prod_flat[c*W +: W];
            end else if (c < N/2) begin : g_left
                assign sel_flat[(r*N+c)*W +: W] =
                    left_quiet ? prod_flat[c*W +: W] : prod_flat[(r*N+c)*W +: W];
            end else begin : g_right
                assign sel_flat[(r*N+c)*W +: W] =
                    right_quiet ? prod_flat[c*W +: W] : prod_flat[(r*N+c)*W +: W];
            end
        end
    end
endmodule

// File: rtl/idq_dequant.sv
module idq_dequant #(
    parameter  int N  = 8,
    parameter  int W  = 16,
    localparam int RW = N * W,
    localparam int BW = N * RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          row_valid,
    output logic          row_ready,
    input  logic [RW-1:0] row_coef,
    input  logic [RW-1:0] row_scale,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [BW-1:0] res_data,
    output logic          res_left_quiet,
    output logic          res_right_quiet
);
    import idq_pkg::*;

    idq_state_e    st_q, st_d;
    logic          wr_en;
    logic          row_last;
    logic [BW-1:0] coef_flat, scale_flat, prod_flat, sel_flat;
    logic          left_quiet, right_quiet;

    assign row_ready = (st_q == ST_LOAD);
    assign res_valid = (st_q == ST_SEND);
    assign wr_en     = row_valid && row_ready;

    idq_row_store #(.N(N), .W(W)) store_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .coef_row    (row_coef),
        .scale_row   (row_scale),
        .row_last    (row_last),
        .coef_flat   (coef_flat),
        .scale_flat  (scale_flat),
        .left_quiet  (left_quiet),
        .right_quiet (right_quiet)
    );

    for (genvar g = 0; g < N*N; g++) begin : g_mul
        idq_lane_mult #(.W(W)) mul_i (
            .coef  (coef_flat[g*W +: W]),
            .scale (scale_flat[g*W +: W]),
            .prod  (prod_flat[g*W +: W])
        );
    end

    idq_fill_select #(.N(N), .W(W)) fill_i (
        .prod_flat   (prod_flat),
        .left_quiet  (left_quiet),
        .right_quiet (right_quiet),
        .sel_flat    (sel_flat)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD: if (wr_en && row_last) st_d = ST_EVAL;
            ST_EVAL: st_d = ST_SEND;
            ST_SEND: if (res_ready) st_d = ST_LOAD;
            default: st_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_LOAD;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data        <= '0;
            res_left_quiet  <= 1'b0;
            res_right_quiet <= 1'b0;
        end else if (st_q == ST_EVAL) begin
            res_data        <= sel_flat;
            res_left_quiet  <= left_quiet;
            res_right_quiet <= right_quiet;
        end
    end
endmodule

// File: rtl/idq_dequant_chk.sv
module idq_dequant_chk #(
    parameter  int N  = 8,
    parameter  int W  = 16,
    localparam int BW = N * N * W,
    localparam int CW = $clog2(N + 1) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          row_valid,
    input logic          row_ready,
    input logic          res_valid,
    input logic          res_ready,
    input logic [BW-1:0] res_data,
    input logic          res_left_quiet,
    input logic          res_right_quiet
);
    logic [CW-1:0] taken_q;

    always_ff @(posedge clk) begin
        if (rst) taken_q <= '0;
        else if (res_valid && res_ready) taken_q <= '0;
        else if (row_valid && row_ready) taken_q <= taken_q + CW'(1);
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) && !rst |-> !res_valid && row_ready);

    a_r2_no_load_in_send: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !row_ready);

    a_r2_row_cap: assert property (@(posedge clk) disable iff (rst)
        (row_valid && row_ready) |-> taken_q < CW'(N));

    a_r10_full_block: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> taken_q == CW'(N));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_data)
            && $stable(res_left_quiet) && $stable(res_right_quiet));

    for (genvar r = 1; r < N; r++) begin : g_r
        for (genvar c = 0; c < N; c++) begin : g_c
            if (c < N/2) begin : g_l
                a_r7_fill_left: assert property (@(posedge clk) disable iff (rst)
                    res_valid && res_left_quiet |->
                        res_data[(r*N+c)*W +: W] == res_data[c*W +: W]);
            end else begin : g_rt
                a_r7_fill_right: assert property (@(posedge clk) disable iff (rst)
                    res_valid && res_right_quiet |->
                        res_data[(r*N+c)*W +: W] == res_data[c*W +: W]);
            end
        end
    end
endmodule

bind idq_dequant idq_dequant_chk #(.N(N), .W(W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .row_valid       (row_valid),
    .row_ready       (row_ready),
    .res_valid       (res_valid),
    .res_ready       (res_ready),
    .res_data        (res_data),
    .res_left_quiet  (res_left_quiet),
    .res_right_quiet (res_right_quiet)
);

// File: tb/idq_dequant_tb_top.sv
module idq_dequant_tb_top;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int RW = N * W;
    localparam int BW = N * RW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          row_valid = 1'b0;
    logic          row_ready;
    logic [RW-1:0] row_coef = '0;
    logic [RW-1:0] row_scale = '0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic [BW-1:0] res_data;
    logic          res_left_quiet, res_right_quiet;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [W-1:0] cf [N][N];
    logic [W-1:0] mf [N][N];

    always #4 clk = ~clk;

    idq_dequant #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst(rst), .row_valid(row_valid), .row_ready(row_ready),
        .row_coef(row_coef), .row_scale(row_scale), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data),
        .res_left_quiet(res_left_quiet), .res_right_quiet(res_right_quiet)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lane(input int r, input int c);
        return res_data[(r*N+c)*W +: W];
    endfunction

    function automatic bit half_quiet(input int lo);
        for (int r = 1; r < N; r++)
            for (int c = lo; c < lo + N/2; c++)
                if (cf[r][c] != '0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic load_rows(input int count);
        for (int r = 0; r < count; r++) begin
            @(negedge clk);
            row_valid = 1'b1;
            for (int c = 0; c < N; c++) begin
                row_coef[c*W +: W]  = cf[r][c];
                row_scale[c*W +: W] = mf[r][c];
            end
            @(posedge clk);
        end
        @(negedge clk);
        row_valid = 1'b0;
    endtask

    task automatic run_block(input int stall);
        int lat;
        bit lq, rq;
        logic [BW-1:0] snap;
        logic [W-1:0] e;
        load_rows(N);
        lat = 1;
        while (!res_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R10 latency", lat, 2);
        check("R2 ready low in send", int'(row_ready), 0);
        lq = half_quiet(0);
        rq = half_quiet(N/2);
        check("R4 R5 left flag", int'(res_left_quiet), int'(lq));
        check("R4 R5 right flag", int'(res_right_quiet), int'(rq));
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (r != 0 && ((c < N/2) ? lq : rq)) begin
                    e = cf[0][c] * mf[0][c];
                    check(lq && rq ? "R6 all dc" : "R7 half dc", int'(lane(r, c)), int'(e));
                end else begin
                    e = cf[r][c] * mf[r][c];
                    check(r == 0 ? "R3 dc row" : "R8 product", int'(lane(r, c)), int'(e));
                end
            end
        end
        snap = res_data;
        for (int s = 0; s < stall; s++) begin
            row_valid = 1'b1;
            row_coef  = {N{16'h5A5A}};
            row_scale = {N{16'h0003}};
            @(negedge clk);
        end
        row_valid = 1'b0;
        if (stall > 0) begin
            check("R9 still valid", int'(res_valid), 1);
            check("R9 data held", int'(res_data == snap), 1);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check("R9 send ends", int'(res_valid), 0);
        check("R2 ready back", int'(row_ready), 1);
    endtask

    task automatic fill_random(input int mode, input int it);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                cf[r][c] = W'($urandom);
                mf[r][c] = W'($urandom);
                if (r != 0 && c <  N/2 && mode[0]) cf[r][c] = '0;
                if (r != 0 && c >= N/2 && mode[1]) cf[r][c] = '0;
                if (r != 0 && (it % 3) == 0) mf[r][c] = '0;
                if (r == 0 && (it % 4) == 1) cf[r][c] = '0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid low", int'(res_valid), 0);
        check("R1 ready high", int'(row_ready), 1);

        // R4 sweep: one non-zero AC coefficient at each AC position
        for (int p = N; p < N*N; p++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    cf[r][c] = (r == 0) ? W'(c + 7) : '0;
                    mf[r][c] = W'(r + c + 1);
                end
            cf[p / N][p % N] = W'(p);
            run_block(0);
        end

        // R6 R7 random sweep over the four quiet combinations
        for (int mode = 0; mode < 4; mode++)
            for (int it = 0; it < 12; it++) begin
                fill_random(mode, it);
                run_block(it % 3);
            end

        // R8 wrap-around: 0x0100*0x0101 and -3*5
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                cf[r][c] = (c % 2 == 0) ? 16'h0100 : 16'hFFFD;
                mf[r][c] = (c % 2 == 0) ? 16'h0101 : 16'h0005;
            end
        run_block(0);
        check("R8 wrap positive", int'(lane(3, 2)), 16'h0100);
        check("R8 wrap negative", int'(lane(3, 3)), 16'hFFF1);

        // R1 reset during load, then a clean block
        fill_random(0, 1);
        load_rows(3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(row_ready), 1);
        fill_random(2, 2);
        run_block(1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule